// File: doc/BRIEF.md
# Serial Register Bus Slave

This block is the device side of a four-wire serial control port. A host drives a chip select, a serial clock and a command-data line, and receives a reply-data line. Every transaction opens with one address byte. Data bytes may follow in one direction only: into a write-only control register, or out of a read-only register. One address carries no data and acts as a command that clears all write-only registers.

The block runs on its own system clock and oversamples the three host lines through a synchronizer. It keeps the write-only registers and presents them on parallel outputs. Status words, modem status words and received data come in on parallel inputs and are serialized on reads. An active-low interrupt output is formed from one status bit gated by one control-register enable bit.

Bytes travel most significant bit first. For 16-bit registers the high byte goes first.

Top module: `srb_slave`

## Requirements
- R1: After rst_n is released, every write-only register output is 0, irq_n is 1 and rpl_out is 0.
- R2: Writable 16-bit registers are at 0xE0 (gen_ctrl), 0xE1 (tx_mode), 0xE2 (rx_mode), 0xE8 (prog) and 0xEA (qam_cmd). Each takes the first data byte as bits 15:8 and the second as bits 7:0. The register updates only after the second byte completes. A transaction with a single data byte leaves it unchanged.
- R3: Address 0xE3 (tx_data) takes two data bytes as a 16-bit value. A transaction with exactly one data byte stores {8'h00, byte} when chip select rises.
- R4: Address 0xE4 (tx_alt, 8 bits) takes the first data byte. Later bytes in the same transaction are ignored.
- R5: Reads of 0xE5 (rx_data_in), 0xE6 (stat_in) and 0xEB (qstat_in) shift out bit 15 first. The first reply bit is driven from the serial-clock falling edge that follows the eighth address bit. The reply changes only on falling edges, so it is stable while the serial clock is high. After 16 bits it shifts out zeros. A read of any other address returns zeros.
- R6: Data written to any address other than 0xE0–0xE4, 0xE8 and 0xEA changes no register. This includes the test addresses 0xE7, 0xE9 and 0xEC–0xEF.
- R7: The address-only command 0x01 returns all write-only registers to 0.
- R8: Raising chip select mid-byte discards the partial byte and restarts framing, so the next transaction starts with a fresh address byte. A 16-bit write cut off before its second byte completes changes nothing.
- R9: irq_n is 0 exactly when stat_in bit 15 and gen_ctrl bit 6 are both 1, one system clock after they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| sclk | input | 1 | Host serial clock |
| cmd_in | input | 1 | Command data from host |
| rpl_out | output | 1 | Reply data to host |
| irq_n | output | 1 | Interrupt request, active low |
| stat_in | input | 16 | Status word read at 0xE6 |
| qstat_in | input | 16 | Modem status word read at 0xEB |
| rx_data_in | input | 16 | Received data read at 0xE5 |
| gen_ctrl | output | 16 | General control register |
| tx_mode | output | 16 | Transmit mode register |
| rx_mode | output | 16 | Receive mode register |
| tx_data | output | 16 | Transmit data register |
| tx_alt | output | 8 | Alternate transmit data register |
| prog | output | 16 | Programming register |
| qam_cmd | output | 16 | Modem command register |

## Verification
The bench builds the block with the default two-stage synchronizer and drives a serial clock of ten system cycles per bit. That timing makes a full sweep of all 256 addresses affordable in both directions. Every write is compared against an arithmetic model of the whole register set, and every read is compared against the word selected by its address. Reply stability is sampled twice in each high phase, and directed cases cover the single-byte, aborted, reset-command and interrupt combinations.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    localparam logic [7:0] A_RESET  = 8'h01;
    localparam logic [7:0] A_GCTRL  = 8'hE0;
    localparam logic [7:0] A_TXMODE = 8'hE1;
    localparam logic [7:0] A_RXMODE = 8'hE2;
    localparam logic [7:0] A_TXDATA = 8'hE3;
    localparam logic [7:0] A_TXALT  = 8'hE4;
    localparam logic [7:0] A_RXDATA = 8'hE5;
    localparam logic [7:0] A_STATUS = 8'hE6;
    localparam logic [7:0] A_PROG   = 8'hE8;
    localparam logic [7:0] A_QCMD   = 8'hEA;
    localparam logic [7:0] A_QSTAT  = 8'hEB;

    localparam int IRQ_STAT_BIT = 15;
    localparam int IRQ_EN_BIT   = 6;
endpackage

// File: rtl/srb_sync.sv
module srb_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{INIT}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/srb_frame.sv
module srb_frame
    import srb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [REG_W-1:0]  rd_word,
    output logic              addr_stb,
    output logic              data_stb,
    output logic              end_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic [1:0]        byte_idx,
    output logic              have_addr,
    output logic [7:0]        cur_addr,
    output logic              sdo
);
    typedef struct packed {
        logic              sclk_prev;
        logic              cs_prev;
        logic [2:0]        bit_cnt;
        logic [BYTE_W-2:0] sh;
        logic              have_addr;
        logic [7:0]        addr;
        logic [1:0]        nbytes;
        logic              rd_pend;
        logic [REG_W-1:0]  rsh;
    } frame_t;

    frame_t q, n;
    logic rise, fall;

    always_comb begin
        n        = q;
        addr_stb = 1'b0;
        data_stb = 1'b0;
        end_stb  = 1'b0;
        rise     = ~cs_n_s & sclk_s & ~q.sclk_prev;
        fall     = ~cs_n_s & ~sclk_s & q.sclk_prev;
        byte_val = {q.sh, sdi_s};
        n.sclk_prev = sclk_s;
        n.cs_prev   = cs_n_s;
        if (cs_n_s) begin
            n.bit_cnt   = '0;
            n.have_addr = 1'b0;
            n.nbytes    = '0;
            n.rd_pend   = 1'b0;
            n.rsh       = '0;
            end_stb     = ~q.cs_prev;
        end else begin
            if (rise) begin
                n.sh      = byte_val[BYTE_W-2:0];
                n.bit_cnt = q.bit_cnt + 3'd1;
                if (q.bit_cnt == 3'd7) begin
                    if (!q.have_addr) begin
                        addr_stb    = 1'b1;
                        n.have_addr = 1'b1;
                        n.addr      = byte_val;
                        n.rd_pend   = 1'b1;
                    end else begin
                        data_stb = 1'b1;
                        if (q.nbytes != 2'd3) n.nbytes = q.nbytes + 2'd1;
                    end
                end
            end
            if (fall) begin
                if (q.rd_pend) begin
                    n.rd_pend = 1'b0;
                    n.rsh     = rd_word;
                end else if (q.have_addr) begin
                    n.rsh = {q.rsh[REG_W-2:0], 1'b0};
                end
            end
        end
        byte_idx  = q.nbytes;
        have_addr = q.have_addr;
        cur_addr  = q.addr;
        sdo       = q.rsh[REG_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.cs_prev   <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assert_reply_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rsh != $past(q.rsh)) |-> ($past(fall) || $past(cs_n_s)));

    assert_addr_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> (q.have_addr && q.rd_pend));

    assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (q.bit_cnt == 3'd0 && !q.have_addr));
endmodule

// File: rtl/srb_regs.sv
module srb_regs
    import srb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_stb,
    input  logic              data_stb,
    input  logic              end_stb,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [1:0]        byte_idx,
    input  logic              have_addr,
    input  logic [7:0]        cur_addr,
    input  logic [REG_W-1:0]  stat_in,
    input  logic [REG_W-1:0]  qstat_in,
    input  logic [REG_W-1:0]  rx_data_in,
    output logic [REG_W-1:0]  rd_word,
    output logic [REG_W-1:0]  gen_ctrl,
    output logic [REG_W-1:0]  tx_mode,
    output logic [REG_W-1:0]  rx_mode,
    output logic [REG_W-1:0]  tx_data,
    output logic [BYTE_W-1:0] tx_alt,
    output logic [REG_W-1:0]  prog,
    output logic [REG_W-1:0]  qam_cmd,
    output logic              irq_n
);
    typedef struct packed {
        logic [REG_W-1:0]  gctrl;
        logic [REG_W-1:0]  txmode;
        logic [REG_W-1:0]  rxmode;
        logic [REG_W-1:0]  txdata;
        logic [BYTE_W-1:0] txalt;
        logic [REG_W-1:0]  prog;
        logic [REG_W-1:0]  qcmd;
        logic [BYTE_W-1:0] hi;
        logic              irq_n;
    } bank_t;

    bank_t q, n;
    logic [REG_W-1:0] word;
    logic reserved;

    always_comb begin
        n    = q;
        word = {q.hi, byte_val};
        if (addr_stb && byte_val == A_RESET) begin
            n.gctrl  = '0;
            n.txmode = '0;
            n.rxmode = '0;
            n.txdata = '0;
            n.txalt  = '0;
            n.prog   = '0;
            n.qcmd   = '0;
        end
        if (data_stb) begin
            if (byte_idx == 2'd0) begin
                n.hi = byte_val;
                if (cur_addr == A_TXALT) n.txalt = byte_val;
            end else if (byte_idx == 2'd1) begin
                case (cur_addr)
                    A_GCTRL:  n.gctrl  = word;
                    A_TXMODE: n.txmode = word;
                    A_RXMODE: n.rxmode = word;
                    A_TXDATA: n.txdata = word;
                    A_PROG:   n.prog   = word;
                    A_QCMD:   n.qcmd   = word;
                    default:  ;
                endcase
            end
        end
        if (end_stb && have_addr && byte_idx == 2'd1 && cur_addr == A_TXDATA)
            n.txdata = {{(REG_W-BYTE_W){1'b0}}, q.hi};
        n.irq_n = ~(stat_in[IRQ_STAT_BIT] & q.gctrl[IRQ_EN_BIT]);

        case (cur_addr)
            A_RXDATA: rd_word = rx_data_in;
            A_STATUS: rd_word = stat_in;
            A_QSTAT:  rd_word = qstat_in;
            default:  rd_word = '0;
        endcase
        reserved = (cur_addr == 8'hE7) || (cur_addr == 8'hE9) || (cur_addr[7:2] == 6'b111011);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.irq_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign gen_ctrl = q.gctrl;
    assign tx_mode  = q.txmode;
    assign rx_mode  = q.rxmode;
    assign tx_data  = q.txdata;
    assign tx_alt   = q.txalt;
    assign prog     = q.prog;
    assign qam_cmd  = q.qcmd;
    assign irq_n    = q.irq_n;

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_in[IRQ_STAT_BIT] && q.gctrl[IRQ_EN_BIT]) |-> !q.irq_n);

    assert_reset_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb && byte_val == A_RESET) |=>
            (q.gctrl == '0 && q.txmode == '0 && q.rxmode == '0 && q.txdata == '0 &&
             q.txalt == '0 && q.prog == '0 && q.qcmd == '0));

    assert_reserved_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && reserved) |=>
            ($stable(q.gctrl) && $stable(q.txmode) && $stable(q.rxmode) && $stable(q.txdata) &&
             $stable(q.txalt) && $stable(q.prog) && $stable(q.qcmd)));

    assert_short_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (end_stb && have_addr && byte_idx == 2'd1 && cur_addr == A_TXDATA) |=>
            (q.txdata[REG_W-1:BYTE_W] == '0));
endmodule

// File: rtl/srb_slave.sv
module srb_slave
    import srb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              cmd_in,
    output logic              rpl_out,
    output logic              irq_n,
    input  logic [REG_W-1:0]  stat_in,
    input  logic [REG_W-1:0]  qstat_in,
    input  logic [REG_W-1:0]  rx_data_in,
    output logic [REG_W-1:0]  gen_ctrl,
    output logic [REG_W-1:0]  tx_mode,
    output logic [REG_W-1:0]  rx_mode,
    output logic [REG_W-1:0]  tx_data,
    output logic [BYTE_W-1:0] tx_alt,
    output logic [REG_W-1:0]  prog,
    output logic [REG_W-1:0]  qam_cmd
);
    logic [2:0] pins_s;
    logic addr_stb, data_stb, end_stb, have_addr;
    logic [BYTE_W-1:0] byte_val;
    logic [1:0] byte_idx;
    logic [7:0] cur_addr;
    logic [REG_W-1:0] rd_word;

    srb_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, cmd_in}), .q(pins_s)
    );

    srb_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
        .rd_word(rd_word),
        .addr_stb(addr_stb), .data_stb(data_stb), .end_stb(end_stb),
        .byte_val(byte_val), .byte_idx(byte_idx),
        .have_addr(have_addr), .cur_addr(cur_addr), .sdo(rpl_out)
    );

    srb_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr_stb(addr_stb), .data_stb(data_stb), .end_stb(end_stb),
        .byte_val(byte_val), .byte_idx(byte_idx),
        .have_addr(have_addr), .cur_addr(cur_addr),
        .stat_in(stat_in), .qstat_in(qstat_in), .rx_data_in(rx_data_in),
        .rd_word(rd_word),
        .gen_ctrl(gen_ctrl), .tx_mode(tx_mode), .rx_mode(rx_mode),
        .tx_data(tx_data), .tx_alt(tx_alt), .prog(prog), .qam_cmd(qam_cmd),
        .irq_n(irq_n)
    );
endmodule

// File: tb/sim_srb_slave.sv
module sim_srb_slave;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, cmd_in = 1'b0;
    logic rpl_out, irq_n;
    logic [15:0] stat_in = '0, qstat_in = '0, rx_data_in = '0;
    logic [15:0] gen_ctrl, tx_mode, rx_mode, tx_data, prog, qam_cmd;
    logic [7:0]  tx_alt;
    int checks = 0, fails = 0, stab_bad = 0;
    logic [15:0] m_gc, m_txm, m_rxm, m_txd, m_prog, m_qc;
    logic [7:0]  m_alt;

    always #4 clk = ~clk;

    srb_slave u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .cmd_in(cmd_in),
        .rpl_out(rpl_out), .irq_n(irq_n),
        .stat_in(stat_in), .qstat_in(qstat_in), .rx_data_in(rx_data_in),
        .gen_ctrl(gen_ctrl), .tx_mode(tx_mode), .rx_mode(rx_mode),
        .tx_data(tx_data), .tx_alt(tx_alt), .prog(prog), .qam_cmd(qam_cmd)
    );

    function automatic logic [103:0] snap_act();
        return {gen_ctrl, tx_mode, rx_mode, tx_data, tx_alt, prog, qam_cmd};
    endfunction

    function automatic logic [103:0] snap_exp();
        return {m_gc, m_txm, m_rxm, m_txd, m_alt, m_prog, m_qc};
    endfunction

    task automatic chk(input string tag, input logic [103:0] act, input logic [103:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic sbit(input logic b, output logic r);
        cmd_in = b;
        repeat (5) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        r = rpl_out;
        repeat (2) @(negedge clk);
        if (rpl_out !== r) stab_bad++;
        @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] a, input int n, input logic [23:0] wd,
                        output logic [23:0] rd);
        logic r;
        rd = '0;
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 7; i >= 0; i--) sbit(a[i], r);
        for (int i = n - 1; i >= 0; i--) begin
            sbit(wd[i], r);
            rd = {rd[22:0], r};
        end
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [23:0] rd;
        logic r;
        m_gc = '0; m_txm = '0; m_rxm = '0; m_txd = '0; m_prog = '0; m_qc = '0; m_alt = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 regs", snap_act(), snap_exp());
        chk("R1 irq_n/rpl_out", {102'd0, irq_n, rpl_out}, {102'd0, 1'b1, 1'b0});

        // R2 R3 R4 R6: write sweep over every address, value {a,~a}
        for (int a = 0; a < 256; a++) begin
            logic [7:0] ab;
            logic [15:0] v;
            string tag;
            ab = 8'(a);
            v  = {ab, ~ab};
            xfer(ab, 16, {8'h00, v}, rd);
            tag = "R6 write ignored";
            case (ab)
                8'h01: begin
                    m_gc = '0; m_txm = '0; m_rxm = '0; m_txd = '0;
                    m_prog = '0; m_qc = '0; m_alt = '0; tag = "R7 reset cmd";
                end
                8'hE0: begin m_gc = v;   tag = "R2 gen_ctrl"; end
                8'hE1: begin m_txm = v;  tag = "R2 tx_mode"; end
                8'hE2: begin m_rxm = v;  tag = "R2 rx_mode"; end
                8'hE3: begin m_txd = v;  tag = "R3 tx_data 16"; end
                8'hE4: begin m_alt = ab; tag = "R4 tx_alt"; end
                8'hE8: begin m_prog = v; tag = "R2 prog"; end
                8'hEA: begin m_qc = v;   tag = "R2 qam_cmd"; end
                default: ;
            endcase
            chk(tag, snap_act(), snap_exp());
        end

        // R5: read sweep over every address
        for (int a = 0; a < 256; a++) begin
            logic [7:0] ab;
            logic [15:0] e;
            ab = 8'(a);
            stat_in    = {~ab, ab};
            qstat_in   = {ab, ab ^ 8'hC3};
            rx_data_in = {ab ^ 8'h5A, ab};
            e = (ab == 8'hE5) ? rx_data_in : (ab == 8'hE6) ? stat_in :
                (ab == 8'hEB) ? qstat_in : 16'h0000;
            xfer(ab, 16, 24'h0, rd);
            chk("R5 read word", {88'd0, rd[15:0]}, {88'd0, e});
        end

        // R5: beyond 16 bits shifts zeros; idle reply low
        stat_in = 16'hB5A7;
        xfer(8'hE6, 24, 24'hFFFFFF, rd);
        chk("R5 24-bit read", {80'd0, rd}, {80'd0, 16'hB5A7, 8'h00});
        chk("R5 idle reply low", {103'd0, rpl_out}, 104'd0);
        chk("R5 reply stable while sclk high", 104'(stab_bad), 104'd0);

        // R7: reset command clears everything
        xfer(8'h01, 0, 24'h0, rd);
        m_gc = '0; m_txm = '0; m_rxm = '0; m_txd = '0; m_prog = '0; m_qc = '0; m_alt = '0;
        chk("R7 reset cmd", snap_act(), snap_exp());

        // R3: single byte to tx_data
        xfer(8'hE3, 8, 24'h0000C5, rd);
        m_txd = 16'h00C5;
        chk("R3 tx_data 8-bit", snap_act(), snap_exp());

        // R2: single byte to a 16-bit register leaves it unchanged
        xfer(8'hE0, 16, 24'h001234, rd);
        m_gc = 16'h1234;
        xfer(8'hE0, 8, 24'h0000AB, rd);
        chk("R2 one byte no commit", snap_act(), snap_exp());

        // R4: extra bytes to tx_alt ignored
        xfer(8'hE4, 16, 24'h00719C, rd);
        m_alt = 8'h71;
        chk("R4 tx_alt first byte", snap_act(), snap_exp());

        // R8: abort mid-address, then a clean transaction
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5; i++) sbit(1'b1, r);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        xfer(8'hE1, 16, 24'h00BEEF, rd);
        m_txm = 16'hBEEF;
        chk("R8 abort then write", snap_act(), snap_exp());
        // R8: cut-off second byte
        xfer(8'hE2, 12, 24'h000ABC, rd);
        chk("R8 partial write ignored", snap_act(), snap_exp());

        // R9: interrupt gating over all four combinations
        for (int k = 0; k < 4; k++) begin
            xfer(8'hE0, 16, {8'h00, (k[0] ? 16'h0040 : 16'h0000)}, rd);
            stat_in = k[1] ? 16'h8000 : 16'h7FFF;
            repeat (3) @(negedge clk);
            chk("R9 irq_n", {103'd0, irq_n}, {103'd0, ~(k[0] & k[1])});
        end
        summary();
    end
endmodule